// File: doc/BRIEF.md
# Inclusive Two-Level Cache Back-Invalidation Controller

This controller keeps the tag state of a small two-level cache hierarchy inclusive, so that every line valid in the first level is also valid in the second. The first level is direct-mapped with 16 lines of one block each. The second level is 2-way set-associative with 8 sets. Each of its lines covers four consecutive first-level blocks. Addresses are 16-bit and count first-level blocks. Bits [3:0] index the first level and bits [15:4] form its tag. Bits [15:2] name the covering second-level block. Within that block, bits [4:2] select the set, bits [15:5] form the tag, and bits [1:0] give the sub-block offset.

Requests arrive on a valid/ready stream. A request is either a processor access, which models a first-level lookup, or an external snoop invalidation. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the sender must hold its request until it is taken. Every first-level tag write is reported on the command pins in the cycle after that write, as a fill or an invalidate. Each request ends with a one-cycle `done` pulse that carries a result code. The command and done pins apply no back-pressure.

When a second-level replacement or a snoop hit removes a valid second-level line, the controller probes the four first-level sub-blocks of that line in ascending order, one per cycle. It invalidates those still held and keeps `busy` high for the whole walk. Snoops that miss in the second level stop there and never reach the first level.

Top module: `incl_cache_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, while `busy`, `done` and `l1_cmd_valid` are 0, and both levels are empty, so the first access completes with code 2.
- R2: An access whose block is valid in the first level completes with `done` one cycle after acceptance, with code 0, and issues no command.
- R3: An access that misses the first level and hits the second writes the first level only. One cycle after acceptance, a fill command (`l1_cmd_inval`=0, index = addr[3:0], tag = addr[15:4]) and `done` with code 1 appear.
- R4: An access that misses both levels, into a set that still has an invalid way, installs the block in both levels. One cycle after acceptance, a fill command and `done` with code 2 appear.
- R5: A second-level set fills its invalid ways first (way 0 before way 1). Once both ways are valid, it replaces the least recently used way. Second-level hits and fills count as uses; first-level hits do not.
- R6: When an access misses both levels and the chosen victim is valid, the controller probes sub-blocks 0 to 3 of the victim on cycles 2 to 5 after acceptance. Each probe that finds its sub-block present issues an invalidate command on that cycle. The fill command and `done` with code 2 follow on cycle 6.
- R7: A probe that finds its first-level line invalid, or holding a different tag, leaves that line unchanged and issues no command.
- R8: A snoop whose block (addr[15:2]) hits in the second level invalidates that line and walks its four sub-blocks as in R6 and R7. `done` with code 4 appears on cycle 5 after acceptance.
- R9: A snoop that misses in the second level completes with code 3 one cycle after acceptance and issues no command.
- R10: During a walk and the fill that follows it, `busy` is 1 and `req_ready` is 0. In the cycle where `done` appears, `busy` is back to 0.
- R11: Whenever the controller is idle, every valid first-level line is covered by a valid second-level line. A block removed from the second level therefore misses in both levels on its next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and taking requests |
| req_snoop | input | 1 | 1 = snoop invalidation, 0 = processor access |
| req_addr | input | 16 | Block-granular address |
| busy | output | 1 | Walk or post-walk fill in progress |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 3 | 0 L1 hit, 1 L2 hit, 2 fill both, 3 snoop filtered, 4 snoop hit |
| l1_cmd_valid | output | 1 | A first-level tag write happened in the last cycle |
| l1_cmd_inval | output | 1 | 1 = invalidate, 0 = fill |
| l1_cmd_index | output | 4 | First-level line index written |
| l1_cmd_tag | output | 12 | First-level tag of the block written |

## Verification
A wrong second-level tag or LRU bit shows at the ports on the next access to the affected set, as the wrong result code or a walk over the wrong victim. A first-level line left behind by a faulty walk shows as a code 0 hit where a miss was due, and a missing or misplaced invalidate shows during the walk itself, within five cycles of acceptance. The bench runs a reference model of both tag levels over full address sweeps and a long pseudo-random mix, so a divergence is caught on the first request that touches the damaged entry.

// File: rtl/incl_pkg.sv
package incl_pkg;
  parameter int ADDR_W   = 16;
  parameter int L1_IDX_W = 4;
  parameter int SUB_W    = 2;
  parameter int L2_SET_W = 3;

  typedef enum logic [2:0] {
    RES_L1_HIT       = 3'd0,
    RES_L2_HIT       = 3'd1,
    RES_FILL_BOTH    = 3'd2,
    RES_SNP_FILTERED = 3'd3,
    RES_SNP_HIT      = 3'd4
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FILL = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/incl_l1_tags.sv
module incl_l1_tags #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12,
  localparam int LINES = 1 << IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic                        rd_valid,
  output logic [TAG_W-1:0]            rd_tag,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_valid,
  input  logic [TAG_W-1:0]            wr_tag,
  output logic [LINES-1:0]            tab_valid,
  output logic [LINES-1:0][TAG_W-1:0] tab_tag
);
  logic [LINES-1:0]            vld;
  logic [LINES-1:0][TAG_W-1:0] tg;

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (wr_en) vld[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tg[wr_idx] <= wr_tag;
  end

  assign rd_valid  = vld[rd_idx];
  assign rd_tag    = tg[rd_idx];
  assign tab_valid = vld;
  assign tab_tag   = tg;
endmodule

// File: rtl/incl_l2_tags.sv
module incl_l2_tags #(
  parameter int SET_W = 3,
  parameter int TAG_W = 11,
  localparam int SETS = 1 << SET_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SET_W-1:0]                 lk_set,
  input  logic [TAG_W-1:0]                 lk_tag,
  output logic                             lk_hit,
  output logic                             lk_way,
  output logic                             vic_way,
  output logic                             vic_valid,
  output logic [TAG_W-1:0]                 vic_tag,
  input  logic                             wr_en,
  input  logic [SET_W-1:0]                 wr_set,
  input  logic                             wr_way,
  input  logic                             wr_valid,
  input  logic [TAG_W-1:0]                 wr_tag,
  input  logic                             touch_en,
  input  logic [SET_W-1:0]                 touch_set,
  input  logic                             touch_way,
  output logic [SETS-1:0][1:0]             tab_valid,
  output logic [SETS-1:0][1:0][TAG_W-1:0]  tab_tag
);
  logic [SETS-1:0][1:0]            vld;
  logic [SETS-1:0][1:0][TAG_W-1:0] tg;
  logic [SETS-1:0]                 lru;  // way to replace next
  logic [1:0]                      hitv;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hitv[w] = vld[lk_set][w] && (tg[lk_set][w] == lk_tag);
  end

  assign lk_hit    = |hitv;
  assign lk_way    = hitv[1];
  assign vic_way   = !vld[lk_set][0] ? 1'b0 :
                     !vld[lk_set][1] ? 1'b1 : lru[lk_set];
  assign vic_valid = vld[lk_set][vic_way];
  assign vic_tag   = tg[lk_set][vic_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      lru <= '0;
    end else begin
      if (wr_en) vld[wr_set][wr_way] <= wr_valid;
      if (touch_en) lru[touch_set] <= ~touch_way;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tg[wr_set][wr_way] <= wr_tag;
  end

  assign tab_valid = vld;
  assign tab_tag   = tg;

  // R5
  way_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));
endmodule

// File: rtl/incl_cache_ctrl.sv
module incl_cache_ctrl
  import incl_pkg::*;
#(
  parameter int AW    = incl_pkg::ADDR_W,
  parameter int L1_IW = incl_pkg::L1_IDX_W,
  parameter int SW    = incl_pkg::SUB_W,
  parameter int L2_SW = incl_pkg::L2_SET_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_snoop,
  input  logic [AW-1:0]          req_addr,
  output logic                   busy,
  output logic                   done,
  output logic [2:0]             done_code,
  output logic                   l1_cmd_valid,
  output logic                   l1_cmd_inval,
  output logic [L1_IW-1:0]       l1_cmd_index,
  output logic [AW-L1_IW-1:0]    l1_cmd_tag
);
  localparam int L1_TW  = AW - L1_IW;
  localparam int L2_BW  = AW - SW;
  localparam int L2_TW  = L2_BW - L2_SW;
  localparam int LINES  = 1 << L1_IW;
  localparam int SETS   = 1 << L2_SW;
  localparam int HI_IW  = L1_IW - SW;

  ctl_state_e          state;
  logic                op_snoop_q;
  logic [AW-1:0]       addr_q;
  logic [L2_BW-1:0]    walk_blk;
  logic [SW-1:0]       cnt;

  // request address fields
  logic [L1_IW-1:0] rq_idx;
  logic [L1_TW-1:0] rq_l1tag;
  logic [L2_SW-1:0] rq_set;
  logic [L2_TW-1:0] rq_l2tag;
  assign rq_idx   = req_addr[L1_IW-1:0];
  assign rq_l1tag = req_addr[AW-1:L1_IW];
  assign rq_set   = req_addr[SW +: L2_SW];
  assign rq_l2tag = req_addr[AW-1 -: L2_TW];

  // walk probe fields
  logic [L1_IW-1:0] walk_idx;
  logic [L1_TW-1:0] walk_tag;
  assign walk_idx = {walk_blk[HI_IW-1:0], cnt};
  assign walk_tag = walk_blk[L2_BW-1:HI_IW];

  // first-level array
  logic                         l1_rv, l1_we, l1_wv;
  logic [L1_TW-1:0]             l1_rt, l1_wtag;
  logic [L1_IW-1:0]             l1_ridx, l1_widx;
  logic [LINES-1:0]             l1_tab_v;
  logic [LINES-1:0][L1_TW-1:0]  l1_tab_t;

  assign l1_ridx = (state == ST_WALK) ? walk_idx : rq_idx;

  incl_l1_tags #(.IDX_W(L1_IW), .TAG_W(L1_TW)) u_l1 (
    .clk(clk), .rst_n(rst_n), .rd_idx(l1_ridx), .rd_valid(l1_rv), .rd_tag(l1_rt),
    .wr_en(l1_we), .wr_idx(l1_widx), .wr_valid(l1_wv), .wr_tag(l1_wtag),
    .tab_valid(l1_tab_v), .tab_tag(l1_tab_t));

  // second-level array
  logic                              l2_hit, l2_hway, vic_way, vic_valid;
  logic [L2_TW-1:0]                  vic_tag;
  logic                              l2_we, l2_wway, l2_wv, touch_en, touch_way;
  logic [SETS-1:0][1:0]              l2_tab_v;
  logic [SETS-1:0][1:0][L2_TW-1:0]   l2_tab_t;

  incl_l2_tags #(.SET_W(L2_SW), .TAG_W(L2_TW)) u_l2 (
    .clk(clk), .rst_n(rst_n), .lk_set(rq_set), .lk_tag(rq_l2tag),
    .lk_hit(l2_hit), .lk_way(l2_hway), .vic_way(vic_way), .vic_valid(vic_valid),
    .vic_tag(vic_tag), .wr_en(l2_we), .wr_set(rq_set), .wr_way(l2_wway),
    .wr_valid(l2_wv), .wr_tag(rq_l2tag), .touch_en(touch_en), .touch_set(rq_set),
    .touch_way(touch_way), .tab_valid(l2_tab_v), .tab_tag(l2_tab_t));

  logic fire, acc_l1_hit, probe_hit;
  assign req_ready  = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign fire       = req_valid && req_ready;
  assign acc_l1_hit = l1_rv && (l1_rt == rq_l1tag);
  assign probe_hit  = (state == ST_WALK) && l1_rv && (l1_rt == walk_tag);

  // write steering
  always_comb begin
    l1_we = 1'b0; l1_wv = 1'b1; l1_widx = rq_idx; l1_wtag = rq_l1tag;
    l2_we = 1'b0; l2_wway = l2_hway; l2_wv = 1'b1;
    touch_en = 1'b0; touch_way = l2_hway;
    unique case (state)
      ST_IDLE: if (fire) begin
        if (!req_snoop) begin
          if (!acc_l1_hit) begin
            if (l2_hit) begin
              l1_we = 1'b1; touch_en = 1'b1;
            end else begin
              l2_we = 1'b1; l2_wway = vic_way;
              touch_en = 1'b1; touch_way = vic_way;
              l1_we = !vic_valid;
            end
          end
        end else if (l2_hit) begin
          l2_we = 1'b1; l2_wv = 1'b0;
        end
      end
      ST_WALK: if (probe_hit) begin
        l1_we = 1'b1; l1_wv = 1'b0; l1_widx = walk_idx; l1_wtag = walk_tag;
      end
      ST_FILL: begin
        l1_we = 1'b1; l1_widx = addr_q[L1_IW-1:0]; l1_wtag = addr_q[AW-1:L1_IW];
      end
      default: ;
    endcase
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      op_snoop_q   <= 1'b0;
      addr_q       <= '0;
      walk_blk     <= '0;
      cnt          <= '0;
      done         <= 1'b0;
      done_code    <= 3'd0;
      l1_cmd_valid <= 1'b0;
      l1_cmd_inval <= 1'b0;
      l1_cmd_index <= '0;
      l1_cmd_tag   <= '0;
    end else begin
      done         <= 1'b0;
      l1_cmd_valid <= l1_we;
      l1_cmd_inval <= !l1_wv;
      l1_cmd_index <= l1_widx;
      l1_cmd_tag   <= l1_wtag;
      unique case (state)
        ST_IDLE: if (fire) begin
          op_snoop_q <= req_snoop;
          addr_q     <= req_addr;
          cnt        <= '0;
          if (!req_snoop) begin
            if (acc_l1_hit) begin
              done <= 1'b1; done_code <= RES_L1_HIT;
            end else if (l2_hit) begin
              done <= 1'b1; done_code <= RES_L2_HIT;
            end else if (vic_valid) begin
              walk_blk <= {vic_tag, rq_set};
              state    <= ST_WALK;
            end else begin
              done <= 1'b1; done_code <= RES_FILL_BOTH;
            end
          end else if (l2_hit) begin
            walk_blk <= req_addr[AW-1:SW];
            state    <= ST_WALK;
          end else begin
            done <= 1'b1; done_code <= RES_SNP_FILTERED;
          end
        end
        ST_WALK: begin
          cnt <= cnt + 1'b1;
          if (cnt == '1) begin
            if (op_snoop_q) begin
              state <= ST_IDLE; done <= 1'b1; done_code <= RES_SNP_HIT;
            end else begin
              state <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          state <= ST_IDLE; done <= 1'b1; done_code <= RES_FILL_BOTH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WALK && cnt != '1) |=> (state == ST_WALK && cnt == $past(cnt) + 1'b1));

  // R6
  walk_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WALK) |=> (!l1_cmd_valid || l1_cmd_inval));

  // R10
  walk_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WALK && cnt != '1) |=> (!done && !req_ready));

  // R9
  snoop_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_snoop && !l2_hit) |=>
      (done && done_code == RES_SNP_FILTERED && !l1_cmd_valid));

  // R3
  l2hit_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_snoop && !acc_l1_hit && l2_hit) |=>
      (done && l1_cmd_valid && !l1_cmd_inval && done_code == RES_L2_HIT));

  // R11: every valid first-level line covered while idle
  for (genvar i = 0; i < LINES; i++) begin : g_incl
    localparam logic [L1_IW-1:0] IV = L1_IW'(i);
    logic [AW-1:0]    full;
    logic [L2_SW-1:0] cset;
    logic [L2_TW-1:0] ctag;
    logic             covered;
    assign full    = {l1_tab_t[i], IV};
    assign cset    = full[SW +: L2_SW];
    assign ctag    = full[AW-1 -: L2_TW];
    assign covered = (l2_tab_v[cset][0] && l2_tab_t[cset][0] == ctag) ||
                     (l2_tab_v[cset][1] && l2_tab_t[cset][1] == ctag);
    // R11
    inclusion_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && l1_tab_v[i]) |-> covered);
  end
endmodule

// File: tb/incl_cache_ctrl_test.sv
`timescale 1ns/1ps
module incl_cache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_snoop = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, busy, done, l1_cmd_valid, l1_cmd_inval;
  logic [2:0]  done_code;
  logic [3:0]  l1_cmd_index;
  logic [11:0] l1_cmd_tag;

  int errors = 0;
  int checks = 0;
  int last_code = -1;

  // reference model of both tag levels
  bit          m1v [16];
  logic [11:0] m1t [16];
  bit          m2v [8][2];
  logic [10:0] m2t [8][2];
  bit          mlru [8];

  always #2.5 clk = ~clk;

  incl_cache_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_snoop(req_snoop), .req_addr(req_addr), .busy(busy), .done(done),
    .done_code(done_code), .l1_cmd_valid(l1_cmd_valid), .l1_cmd_inval(l1_cmd_inval),
    .l1_cmd_index(l1_cmd_index), .l1_cmd_tag(l1_cmd_tag));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pack_cmd(int k, bit inv, logic [3:0] idx, logic [11:0] tg);
    return (k << 20) | (int'(inv) << 16) | (int'(idx) << 12) | int'(tg);
  endfunction

  task automatic run_op(input bit snp, input logic [15:0] a);
    int e_cmd [6];
    int g_cmd [8];
    int n_exp = 0, ng = 0, e_lat = 1, e_code = 0, done_k = 0, code = -1;
    bit walked = 0, bad_busy = 0;
    logic [2:0]  set   = a[4:2];
    logic [10:0] btag  = a[15:5];
    logic [3:0]  idx   = a[3:0];
    logic [11:0] t1    = a[15:4];
    int          hway  = -1;
    logic [13:0] blk;
    string tg, tgc;
    for (int w = 0; w < 2; w++) if (m2v[set][w] && m2t[set][w] == btag) hway = w;
    if (!snp) begin
      if (m1v[idx] && m1t[idx] == t1) begin
        e_code = 0;
      end else if (hway >= 0) begin
        e_code = 1;
        e_cmd[n_exp++] = pack_cmd(1, 0, idx, t1);
        m1v[idx] = 1; m1t[idx] = t1; mlru[set] = (hway == 0);
      end else begin
        int vic = !m2v[set][0] ? 0 : (!m2v[set][1] ? 1 : int'(mlru[set]));
        e_code = 2;
        if (m2v[set][vic]) begin
          walked = 1;
          blk = {m2t[set][vic], set};
          for (int j = 0; j < 4; j++) begin
            logic [15:0] sub = {blk, 2'(j)};
            if (m1v[sub[3:0]] && m1t[sub[3:0]] == sub[15:4]) begin
              e_cmd[n_exp++] = pack_cmd(2 + j, 1, sub[3:0], sub[15:4]);
              m1v[sub[3:0]] = 0;
            end
          end
          e_lat = 6;
        end
        e_cmd[n_exp++] = pack_cmd(e_lat, 0, idx, t1);
        m2v[set][vic] = 1; m2t[set][vic] = btag; mlru[set] = (vic == 0);
        m1v[idx] = 1; m1t[idx] = t1;
      end
    end else begin
      if (hway >= 0) begin
        walked = 1; e_code = 4; e_lat = 5;
        m2v[set][hway] = 0;
        blk = a[15:2];
        for (int j = 0; j < 4; j++) begin
          logic [15:0] sub = {blk, 2'(j)};
          if (m1v[sub[3:0]] && m1t[sub[3:0]] == sub[15:4]) begin
            e_cmd[n_exp++] = pack_cmd(2 + j, 1, sub[3:0], sub[15:4]);
            m1v[sub[3:0]] = 0;
          end
        end
      end else begin
        e_code = 3;
      end
    end
    case (e_code)
      0: tg = "R2";
      1: tg = "R3";
      2: tg = walked ? "R6" : "R4";
      3: tg = "R9";
      default: tg = "R8";
    endcase
    tgc = walked ? {tg, ",R7"} : tg;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_snoop = snp; req_addr = a;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (l1_cmd_valid && ng < 8)
        g_cmd[ng++] = pack_cmd(k, l1_cmd_inval, l1_cmd_index, l1_cmd_tag);
      if (k < e_lat && (busy !== 1'b1 || req_ready !== 1'b0)) bad_busy = 1;
      if (k == e_lat && busy !== 1'b0) bad_busy = 1;
      if (done) begin done_k = k; code = int'(done_code); break; end
    end
    chk(done_k == e_lat, tg, "done latency", done_k, e_lat);
    chk(code == e_code, tg, "result code", code, e_code);
    chk(ng == n_exp, tgc, "command count", ng, n_exp);
    for (int j = 0; j < n_exp && j < ng; j++)
      chk(g_cmd[j] == e_cmd[j], tgc, "command word", g_cmd[j], e_cmd[j]);
    chk(!bad_busy, "R10", "busy/ready during operation", int'(bad_busy), 0);
    last_code = code;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 16; i++) begin m1v[i] = 0; m1t[i] = '0; end
    for (int s = 0; s < 8; s++) begin
      mlru[s] = 0;
      for (int w = 0; w < 2; w++) begin m2v[s][w] = 0; m2t[s][w] = '0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done === 1'b0, "R1", "done after reset", int'(done), 0);
    chk(l1_cmd_valid === 1'b0, "R1", "cmd after reset", int'(l1_cmd_valid), 0);
    run_op(0, 16'd0);
    chk(last_code == 2, "R1", "first access misses both", last_code, 2);

    // R5 replacement order, R7 untouched line
    run_op(0, 16'd32);
    run_op(0, 16'd1);
    chk(last_code == 1, "R5", "same block hits second level", last_code, 1);
    run_op(0, 16'd64);  // evicts block of 32, leaves line 1 alone
    run_op(0, 16'd1);
    chk(last_code == 0, "R7", "non-matching line untouched by walk", last_code, 0);
    run_op(0, 16'd33);
    chk(last_code == 2, "R5", "LRU victim was evicted", last_code, 2);

    // R8 snoop hit then R11 block gone from both levels
    run_op(1, 16'd33);
    chk(last_code == 4, "R8", "snoop hit code", last_code, 4);
    run_op(0, 16'd33);
    chk(last_code == 2, "R11", "snooped block misses both levels", last_code, 2);
    run_op(1, 16'd500);
    chk(last_code == 3, "R9", "absent snoop filtered", last_code, 3);

    // sweeps
    for (int a = 0; a < 256; a++) run_op(0, 16'(a));
    for (int a = 0; a < 256; a += 4) run_op(1, 16'(a + 1));
    for (int a = 255; a >= 0; a--) run_op(0, 16'(a));
    for (int a = 0; a < 64; a++) run_op(0, 16'(a * 16 + (a & 3)));
    for (int n = 0; n < 500; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run_op(lf[15:13] == 3'd0, {8'd0, lf[7:0]});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule